// File: doc/BRIEF.md
# Dual Down-Counter Timer Unit with Interrupt Control

This block provides two 16-bit down-counting timers behind a byte-wide register bus, plus the interrupt flag and enable logic that goes with them. Software selects one of sixteen byte registers through address bits 12:9. It programs a start value and then reads the live counts back. Both counters advance only on clock cycles where the tick enable input is high, so one shared prescaler can set the time base for the whole chip.

The first timer has a full 16-bit reload value. After it hits zero it steps once more to all-ones and then reloads, so in free-running mode its period is the reload value plus two ticks. A two-bit mode field selects whether every zero crossing raises the interrupt flag or only the first one after a start. The second timer is a plain one-shot whose start value is assembled from a stored low byte and the high byte written to start it. An external shift-complete pulse can also raise a flag. The interrupt output is active high. It is raised when an enabled flag belonging to the first timer or to the shift event is set.

Top module: `via_timer_pair`

## Requirements
- R1: The register index is bus_addr[12:9]. Index 0 reads the timer-A count low byte and writes the timer-A reload low byte. Index 1 reads the timer-A count high byte and writes start-A. Index 2 is reload-A low and index 3 is reload-A high, both read/write. Index 4 reads the timer-B count low byte and writes the timer-B low byte store. Index 5 reads the timer-B count high byte and writes start-B. Index 6 is the mode register, index 7 the flag register and index 8 the enable register. Indices 9 to 15 read as 0x00.
- R2: After reset the timer-A reload and count are 0xFFFF and the timer-B count is 0xFFFF. The mode, flag and enable registers read 0x00 and irq is low.
- R3: On each tick, timer A goes from N to N-1. From 0 it goes to 0xFFFF, and from 0xFFFF it reloads the reload value, so a free-running period is reload+2 ticks.
- R4: Neither counter changes on a cycle where tick_en is low and no start write occurs.
- R5: Writing index 1 stores the byte as reload-A high, loads the count with the full reload value and clears flag bit 6. Writes to indices 0, 2 and 3 change only the reload value, never the count.
- R6: Flag bit 6 is set by a tick that brings timer A to 0. With mode bits 7:6 equal to 01 it is set at every such crossing. With any other value it is set only at the first crossing after a start write.
- R7: A read of index 0 clears flag bit 6.
- R8: Writing index 5 loads timer B with {byte, stored low byte}. Flag bit 5 is set on the first tick that brings timer B to 0 after that write and not again until the next start-B.
- R9: An enable write with bit 7 = 1 sets the enable bits written as 1 in bits 6:0. With bit 7 = 0 it clears them. Reading index 8 returns {0, enables[6:0]}.
- R10: Writing 1 to a bit of the flag register clears that flag, and writing 0 leaves it unchanged. Reading index 7 returns {irq, flags[6:0]}.
- R11: irq is high exactly when flags & enables & 0x44 is nonzero. A one-cycle shift_done pulse sets flag bit 2. Flag bit 5 never drives irq.
- R12: Indices 0/1 return the live timer-A count and indices 2/3 the stored reload-A bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte address; bits 12:9 select the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects occur at the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| tick_en | input | 1 | Counter advance enable |
| shift_done | input | 1 | Shift-complete event pulse |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest state to reach from the ports is the one-shot behaviour of timer B. Its counter must wrap through all 65536 values after the first expiry so that the bench can show the flag does not return. The bench loads a count of 2, lets it expire and clears the flag, then holds tick_en high for exactly 65536 cycles. After that it checks that the count is back at zero with flag bit 5 still clear. For timer A, the bench counts ticks across the 0, 0xFFFF, reload sequence to confirm the reload+2 period in both mode settings.

// File: rtl/via_tmr_pkg.sv
package via_tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int IDX_W  = 4;
    localparam int FLG_W  = 7;

    localparam int FLG_TA = 6;
    localparam int FLG_TB = 5;
    localparam int FLG_SH = 2;

    localparam logic [FLG_W-1:0] IRQ_SRC_MASK = FLG_W'((1 << FLG_TA) | (1 << FLG_SH));
    localparam logic [1:0]       MODE_FREERUN = 2'b01;

    typedef enum logic [IDX_W-1:0] {
        RG_TA_CLO = 4'd0,
        RG_TA_CHI = 4'd1,
        RG_TA_RLO = 4'd2,
        RG_TA_RHI = 4'd3,
        RG_TB_LO  = 4'd4,
        RG_TB_HI  = 4'd5,
        RG_MODE   = 4'd6,
        RG_FLAGS  = 4'd7,
        RG_ENABLE = 4'd8
    } reg_idx_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } tmr_view_t;

    function automatic logic [FLG_W-1:0] enable_next(input logic [FLG_W-1:0] cur,
                                                     input logic [BYTE_W-1:0] wd);
        return wd[BYTE_W-1] ? (cur | wd[FLG_W-1:0]) : (cur & ~wd[FLG_W-1:0]);
    endfunction

    function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] cnt,
                                                    input logic [CNT_W-1:0] rld,
                                                    input logic             reload_en);
        if (reload_en && (cnt == {CNT_W{1'b1}}))
            return rld;
        return cnt - CNT_W'(1);
    endfunction

endpackage

// File: rtl/via_tmr_core.sv
module via_tmr_core
    import via_tmr_pkg::*;
#(
    parameter bit               RELOAD    = 1'b1,
    parameter bit               HAS_RLDHI = 1'b1,
    parameter logic [CNT_W-1:0] RST_RLD   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_start,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              oneshot,
    output tmr_view_t         view,
    output logic              fire
);

    logic [BYTE_W-1:0] rld_lo;
    logic [BYTE_W-1:0] rld_hi;
    logic [CNT_W-1:0]  cnt_q;
    logic              armed_q;
    logic              reach_zero;

    assign reach_zero = tick && !wr_start && (cnt_q == CNT_W'(1));
    assign fire       = reach_zero && (armed_q || !oneshot);

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_lo <= RST_RLD[BYTE_W-1:0];
        end else if (wr_lo) begin
            rld_lo <= wdata;
        end
    end

    generate
        if (HAS_RLDHI) begin : g_rldhi
            always_ff @(posedge clk) begin
                if (rst) begin
                    rld_hi <= RST_RLD[CNT_W-1:BYTE_W];
                end else if (wr_hi || wr_start) begin
                    rld_hi <= wdata;
                end
            end
        end else begin : g_nohi
            assign rld_hi = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '1;
            armed_q <= 1'b0;
        end else if (wr_start) begin
            cnt_q   <= {wdata, rld_lo};
            armed_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= count_step(cnt_q, {rld_hi, rld_lo}, RELOAD);
            if (reach_zero && oneshot) begin
                armed_q <= 1'b0;
            end
        end
    end

    assign view.cnt = cnt_q;
    assign view.rld = {rld_hi, rld_lo};

endmodule

// File: rtl/via_irq_ctl.sv
module via_irq_ctl
    import via_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_flags,
    input  logic              wr_enable,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [FLG_W-1:0]  set_mask,
    input  logic [FLG_W-1:0]  clr_mask,
    output logic [FLG_W-1:0]  flags,
    output logic [FLG_W-1:0]  enables,
    output logic              irq
);

    logic [FLG_W-1:0] clr_all;

    assign clr_all = clr_mask | (wr_flags ? wdata[FLG_W-1:0] : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags <= (flags & ~clr_all) | set_mask;
            if (wr_enable) begin
                enables <= enable_next(enables, wdata);
            end
        end
    end

    assign irq = |(flags & enables & IRQ_SRC_MASK);

endmodule

// File: rtl/via_timer_pair.sv
module via_timer_pair
    import via_tmr_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int IDX_LSB = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick_en,
    input  logic              shift_done,
    output logic              irq
);

    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] mode_q;
    logic              ta_freerun;
    logic              ta_fire, tb_fire;
    logic              ta_load;
    tmr_view_t         ta_view, tb_view;
    logic [CNT_W-1:0]  ta_cnt, ta_rld;
    logic [FLG_W-1:0]  flags, enables;
    logic [FLG_W-1:0]  set_mask, clr_mask;
    logic              unused_addr_bits;

    assign idx              = bus_addr[IDX_MSB:IDX_LSB];
    assign unused_addr_bits = ^{bus_addr[IDX_LSB-1:0], tb_view.rld};
    assign ta_freerun       = (mode_q[7:6] == MODE_FREERUN);
    assign ta_load          = bus_wr && (idx == RG_TA_CHI);
    assign ta_cnt           = ta_view.cnt;
    assign ta_rld           = ta_view.rld;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (bus_wr && idx == RG_MODE) begin
            mode_q <= bus_wdata;
        end
    end

    via_tmr_core #(
        .RELOAD   (1'b1),
        .HAS_RLDHI(1'b1),
        .RST_RLD  ('1)
    ) u_ta (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .wr_lo   (bus_wr && (idx == RG_TA_CLO || idx == RG_TA_RLO)),
        .wr_hi   (bus_wr && idx == RG_TA_RHI),
        .wr_start(ta_load),
        .wdata   (bus_wdata),
        .oneshot (!ta_freerun),
        .view    (ta_view),
        .fire    (ta_fire)
    );

    via_tmr_core #(
        .RELOAD   (1'b0),
        .HAS_RLDHI(1'b0),
        .RST_RLD  ('0)
    ) u_tb (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .wr_lo   (bus_wr && idx == RG_TB_LO),
        .wr_hi   (1'b0),
        .wr_start(bus_wr && idx == RG_TB_HI),
        .wdata   (bus_wdata),
        .oneshot (1'b1),
        .view    (tb_view),
        .fire    (tb_fire)
    );

    always_comb begin
        set_mask         = '0;
        set_mask[FLG_TA] = ta_fire;
        set_mask[FLG_TB] = tb_fire;
        set_mask[FLG_SH] = shift_done;
        clr_mask         = '0;
        clr_mask[FLG_TA] = (bus_rd && idx == RG_TA_CLO) || ta_load;
    end

    via_irq_ctl u_irq (
        .clk      (clk),
        .rst      (rst),
        .wr_flags (bus_wr && idx == RG_FLAGS),
        .wr_enable(bus_wr && idx == RG_ENABLE),
        .wdata    (bus_wdata),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .flags    (flags),
        .enables  (enables),
        .irq      (irq)
    );

    always_comb begin
        case (idx)
            RG_TA_CLO: bus_rdata = ta_view.cnt[BYTE_W-1:0];
            RG_TA_CHI: bus_rdata = ta_view.cnt[CNT_W-1:BYTE_W];
            RG_TA_RLO: bus_rdata = ta_view.rld[BYTE_W-1:0];
            RG_TA_RHI: bus_rdata = ta_view.rld[CNT_W-1:BYTE_W];
            RG_TB_LO:  bus_rdata = tb_view.cnt[BYTE_W-1:0];
            RG_TB_HI:  bus_rdata = tb_view.cnt[CNT_W-1:BYTE_W];
            RG_MODE:   bus_rdata = mode_q;
            RG_FLAGS:  bus_rdata = {irq, flags};
            RG_ENABLE: bus_rdata = {1'b0, enables};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/via_timer_pair_chk.sv
module via_timer_pair_chk
    import via_tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              ta_load,
    input logic [CNT_W-1:0]  ta_cnt,
    input logic [CNT_W-1:0]  ta_rld,
    input logic [FLG_W-1:0]  flags,
    input logic [FLG_W-1:0]  enables,
    input logic              bus_wr,
    input logic [IDX_W-1:0]  idx,
    input logic [BYTE_W-1:0] bus_wdata
);

    assert_ta_countdown_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !ta_load && ta_cnt != 16'hFFFF) |=> (ta_cnt == $past(ta_cnt) - 16'd1));

    assert_ta_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !ta_load && ta_cnt == 16'hFFFF) |=> (ta_cnt == $past(ta_rld)));

    assert_ta_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !ta_load) |=> $stable(ta_cnt));

    assert_ta_start_R5: assert property (@(posedge clk) disable iff (rst)
        ta_load |=> (ta_cnt == {$past(bus_wdata), $past(ta_rld[7:0])}) && !flags[FLG_TA]);

    assert_ta_flag_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_TA]) |-> (ta_cnt == 16'h0000));

    assert_enable_set_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == 4'd8 && bus_wdata[7]) |=> (enables == ($past(enables) | $past(bus_wdata[6:0]))));

endmodule

bind via_timer_pair via_timer_pair_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .ta_load  (ta_load),
    .ta_cnt   (ta_cnt),
    .ta_rld   (ta_rld),
    .flags    (flags),
    .enables  (enables),
    .bus_wr   (bus_wr),
    .idx      (idx),
    .bus_wdata(bus_wdata)
);

// File: tb/via_timer_pair_tb.sv
module via_timer_pair_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tick_en = 1'b0;
    logic        shift_done = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    via_timer_pair u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .shift_done(shift_done),
        .irq       (irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        bus_addr  = 13'(idx << 9);
        bus_wdata = d;
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [7:0] d);
        bus_addr = 13'(idx << 9) | 13'h0_1A5;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        step();
        bus_rd   = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick_en = 1'b0;
    endtask

    task automatic ta_count(input string req, input int exp);
        logic [7:0] lo, hi;
        rd(1, hi);
        bus_addr = 13'(2 << 9);
        #1 lo = u_dut.bus_rdata;
        bus_addr = 13'(0);
        #1 lo = bus_rdata;
        bus_addr = 13'(1 << 9);
        check(req, {hi, lo}, exp);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R2 irq", int'(irq), 0);
        ta_count("R2 ta count", 16'hFFFF);
        rd(2, d); check("R2 rld lo", d, 8'hFF);
        rd(3, d); check("R2 rld hi", d, 8'hFF);
        rd(4, d); check("R2 tb lo", d, 8'hFF);
        rd(5, d); check("R2 tb hi", d, 8'hFF);
        rd(6, d); check("R2 mode", d, 0);
        rd(7, d); check("R2 flags", d, 0);
        rd(8, d); check("R2 enables", d, 0);
        rd(11, d); check("R1 unused index", d, 0);
    endtask

    task automatic t_oneshot();
        logic [7:0] d;
        wr(6, 8'hC0);
        wr(8, 8'hC0);
        wr(2, 8'h05);
        wr(1, 8'h00);
        ta_count("R5 start loads", 5);
        ticks(4);
        check("R6 before zero", int'(irq), 0);
        ticks(1);
        check("R6 oneshot first zero", int'(irq), 1);
        ta_count("R3 at zero", 0);
        ticks(1);
        ta_count("R3 passes -1", 16'hFFFF);
        ticks(1);
        ta_count("R3 reloads", 5);
        rd(0, d);
        check("R7 read clears flag", int'(irq), 0);
        ticks(5);
        ta_count("R3 second zero", 0);
        check("R6 mode 11 no repeat", int'(irq), 0);
    endtask

    task automatic t_freerun();
        logic [7:0] d;
        wr(7, 8'h7F);
        wr(6, 8'h40);
        wr(0, 8'h03);
        wr(1, 8'h00);
        ticks(3);
        check("R6 freerun first", int'(irq), 1);
        wr(7, 8'h40);
        check("R10 w1c clears", int'(irq), 0);
        ticks(4);
        check("R3 period not yet", int'(irq), 0);
        ticks(1);
        check("R6 freerun repeats at rld+2", int'(irq), 1);
        rd(7, d);
        check("R10 flag read", d, 8'hC0);
        wr(7, 8'h00);
        check("R10 zero write keeps", int'(irq), 1);
        wr(1, 8'h00);
        check("R5 start clears flag", int'(irq), 0);
        step(); step(); step();
        ta_count("R4 no tick holds", 3);
        wr(3, 8'h12);
        wr(2, 8'h34);
        wr(0, 8'h56);
        ta_count("R5 reload writes keep count", 3);
        rd(2, d); check("R12 rld lo", d, 8'h56);
        rd(3, d); check("R12 rld hi", d, 8'h12);
        wr(6, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        wr(8, 8'h7F);
        rd(8, d); check("R9 clear all", d, 0);
        wr(8, 8'hA4);
        rd(8, d); check("R9 set", d, 8'h24);
        wr(8, 8'h04);
        rd(8, d); check("R9 clear one", d, 8'h20);
        wr(8, 8'h84);
    endtask

    task automatic t_shift();
        logic [7:0] d;
        wr(7, 8'h7F);
        shift_done = 1'b1;
        step();
        shift_done = 1'b0;
        check("R11 shift irq", int'(irq), 1);
        rd(7, d); check("R11 shift flag", d, 8'h84);
        wr(7, 8'h04);
        check("R10 shift cleared", int'(irq), 0);
    endtask

    task automatic t_timer_b();
        logic [7:0] d, lo, hi;
        wr(7, 8'h7F);
        wr(4, 8'h02);
        wr(5, 8'h00);
        rd(4, lo); rd(5, hi);
        check("R8 tb load", {hi, lo}, 2);
        ticks(1);
        rd(7, d); check("R8 tb before zero", d & 8'h20, 0);
        ticks(1);
        rd(7, d); check("R8 tb flag", d & 8'h20, 8'h20);
        check("R11 tb not in irq", int'(irq), 0);
        wr(7, 8'h20);
        ticks(65536);
        rd(4, lo); rd(5, hi);
        check("R8 tb wrapped", {hi, lo}, 0);
        rd(7, d); check("R8 tb oneshot", d & 8'h20, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_oneshot();
        t_freerun();
        t_enable();
        t_shift();
        t_timer_b();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule